// File: doc/BRIEF.md
# I2C Data Buffer Handshake

This block owns the single-byte holding buffer between a host register port and an I2C byte shift engine. The host writes bytes that the engine will transmit and reads bytes the engine has received. The engine reports byte boundaries as ACK or NACK pulses, plus start, stop and arbitration-loss events. From these inputs the block produces the transmit-empty, receive-not-empty and byte-transfer-finished flags. It also produces a pulse that tells the engine to load its shift register from the buffer.

When the host falls behind, a mode input selects the response. In stretching mode the block holds SCL low through a stretch request and raises byte-transfer-finished. In no-stretch mode it raises a sticky overrun/underrun flag. On an underrun the last byte is sent again. On an overrun the newly received byte is dropped. The block leaves the stretching state only when the host accesses the buffer after it has read status register 1. An access without that earlier status read has no effect.

The core is one state machine with these states:
- `ST_IDLE`: no data phase.
- `ST_TX_START`: transmitter, buffer empty, shifter idle.
- `ST_TX_EMPTY`: buffer empty, shifter busy.
- `ST_TX_FULL`: a byte is pending in the buffer.
- `ST_TX_STALL`: transmit underrun while stretching.
- `ST_RX_EMPTY`: receiver, buffer empty.
- `ST_RX_FULL`: received byte waiting for the host.
- `ST_RX_STALL`: receive overrun while stretching.

The transitions are:
- begin-data: `ST_IDLE` to a TX or RX state on `addr_done`.
- first-load: `ST_TX_START` to `ST_TX_EMPTY` on a host write.
- queue: `ST_TX_EMPTY` to `ST_TX_FULL` on a host write.
- hand-over: `ST_TX_FULL` to `ST_TX_EMPTY` on ACK.
- tx-underrun: `ST_TX_EMPTY` to `ST_TX_STALL` on ACK while stretching.
- tx-resume: `ST_TX_STALL` to `ST_TX_EMPTY` on an armed write.
- capture: `ST_RX_EMPTY` to `ST_RX_FULL` on ACK.
- drain: `ST_RX_FULL` to `ST_RX_EMPTY` on a host read.
- rx-overrun: `ST_RX_FULL` to `ST_RX_STALL` on ACK while stretching.
- rx-resume: `ST_RX_STALL` to `ST_RX_FULL` on an armed read.
- abort: any state to `ST_IDLE` on start, stop, arbitration loss, a NACK in a TX state, or `enable` low.

Top module: `i2c_dbuf_ctrl`

## Requirements
- R1: After reset, and one cycle after any cycle with `enable`=0, `txe`, `rxne`, `btf`, `stretch`, `ovr` and `tx_load` are all 0.
- R2: `txe` stays 0 until `addr_done` is seen with `dir_tx`=1, and is 1 after that edge. A start or stop event clears `txe`, `rxne` and `btf` at the next edge.
- R3: A host write in `ST_TX_START` captures the byte. `tx_load` is 1 for one cycle after that edge, with `buf_data` equal to the byte, and `txe` stays 1.
- R4: A host write while the shifter is busy and the buffer is empty makes `txe` 0 at the next edge.
- R5: An ACK while a byte is pending gives a one-cycle `tx_load` with that byte and sets `txe` to 1.
- R6: In stretching mode (`no_stretch`=0), an ACK in `ST_TX_EMPTY` sets `btf` and `stretch` to 1, keeps `txe` at 1, and produces no load.
- R7: While `btf`=1, a host read or write that was not preceded by an `sr1_rd` pulse since the last buffer access has no effect: flags, `buf_data` and `tx_load` are unchanged.
- R8: An armed host write in `ST_TX_STALL` gives a `tx_load` of the new byte and clears `btf` and `stretch` at that edge. `txe` stays 1.
- R9: A host write while `txe`=0 is accepted and overwrites the pending byte. The byte loaded at the next ACK is the last one written.
- R10: A NACK in a transmit state produces no load and leaves `txe`=0.
- R11: In no-stretch mode, an ACK in `ST_TX_EMPTY` sets the sticky `ovr` flag and loads the previous byte again. `btf` never rises in this mode.
- R12: An ACK in `ST_RX_EMPTY` copies `rx_byte` into the buffer and sets `rxne`. A host read clears `rxne`. In stretching mode, an ACK in `ST_RX_FULL` raises `btf` and `stretch`. An armed read then copies the held `rx_byte`, clears `btf`, and keeps `rxne` at 1.
- R13: An ACK that coincides with arbitration loss copies nothing. It leaves `rxne` and `btf` at 0 and returns the block to `ST_IDLE`.
- R14: In no-stretch mode, an ACK in `ST_RX_FULL` sets `ovr`, discards the new byte (`buf_data` unchanged) and keeps `rxne` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Peripheral enable; 0 clears all state |
| no_stretch | input | 1 | 1 selects overrun/underrun mode, 0 selects clock stretching |
| addr_done | input | 1 | Pulse: address phase complete, data phase begins |
| dir_tx | input | 1 | Direction at `addr_done`: 1 transmit, 0 receive |
| ev_start | input | 1 | Pulse: start or repeated start seen |
| ev_stop | input | 1 | Pulse: stop seen |
| ev_arlo | input | 1 | Pulse: arbitration lost |
| ev_ack | input | 1 | Pulse: byte boundary with ACK pulse |
| ev_nack | input | 1 | Pulse: byte boundary with NACK |
| rx_byte | input | DW | Byte held in the engine's shift register |
| host_wr | input | 1 | Host write strobe to the data buffer |
| host_rd | input | 1 | Host read strobe of the data buffer |
| host_wdata | input | DW | Host write data |
| sr1_rd | input | 1 | Host read strobe of status register 1 |
| buf_data | output | DW | Buffer contents: shift-load byte and host read data |
| tx_load | output | 1 | One-cycle pulse: engine loads `buf_data` into its shifter |
| txe | output | 1 | Transmit buffer empty |
| rxne | output | 1 | Receive buffer not empty |
| btf | output | 1 | Byte transfer finished (stretching mode) |
| stretch | output | 1 | Request to hold SCL low |
| ovr | output | 1 | Sticky overrun/underrun flag |

## Verification
The hard cases are the two stall states. Reaching them takes two consecutive ACKs with no host service between them, and leaving them correctly depends on the order of the status read and the buffer access. The stimulus first drives each stall and then tries an unarmed access. It checks that nothing moved, including that no load pulse appeared. It then issues `sr1_rd` and repeats the access. In the receive stall, the bench holds a new `rx_byte` on the engine side for the whole stall. This lets it confirm that the armed read picks up that byte, not the one captured earlier.

// File: rtl/i2c_dbuf_pkg.sv
package i2c_dbuf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_START,
        ST_TX_EMPTY,
        ST_TX_FULL,
        ST_TX_STALL,
        ST_RX_EMPTY,
        ST_RX_FULL,
        ST_RX_STALL
    } dbuf_state_e;
endpackage

// File: rtl/i2c_dbuf_arm.sv
// Tracks whether a status-1 read has occurred since the last buffer access.
module i2c_dbuf_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sr1_rd,
    input  logic dr_access,
    output logic armed
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          armed <= 1'b0;
        else if (!enable)    armed <= 1'b0;
        else if (sr1_rd)     armed <= 1'b1;
        else if (dr_access)  armed <= 1'b0;
    end
endmodule

// File: rtl/i2c_dbuf_store.sv
// The one-byte holding register, loaded from the host or from the shifter.
module i2c_dbuf_store #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cap_host,
    input  logic          cap_rx,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rx_byte,
    output logic [DW-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        data_q <= '0;
        else if (!enable)  data_q <= '0;
        else if (cap_host) data_q <= wdata;
        else if (cap_rx)   data_q <= rx_byte;
    end
endmodule

// File: rtl/i2c_dbuf_fsm.sv
module i2c_dbuf_fsm
    import i2c_dbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic no_stretch,
    input  logic addr_done,
    input  logic dir_tx,
    input  logic ev_start,
    input  logic ev_stop,
    input  logic ev_arlo,
    input  logic ev_ack,
    input  logic ev_nack,
    input  logic host_wr,
    input  logic host_rd,
    input  logic armed,
    output logic cap_host,
    output logic cap_rx,
    output logic tx_load,
    output logic txe,
    output logic rxne,
    output logic btf,
    output logic stretch,
    output logic ovr
);
    dbuf_state_e state_q, state_d;
    logic        load_q, load_d;
    logic        ovr_q, ovr_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            load_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            load_q  <= load_d;
            ovr_q   <= ovr_d;
        end
    end

    // Next state: enable, then start/stop, then arbitration loss, then per state
    always_comb begin
        state_d  = state_q;
        load_d   = 1'b0;
        ovr_d    = ovr_q;
        cap_host = 1'b0;
        cap_rx   = 1'b0;
        if (!enable) begin
            state_d = ST_IDLE;
            ovr_d   = 1'b0;
        end else if (ev_start || ev_stop || ev_arlo) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (addr_done) state_d = dir_tx ? ST_TX_START : ST_RX_EMPTY;
                end
                ST_TX_START: begin
                    if (ev_nack) state_d = ST_IDLE;
                    else if (host_wr) begin
                        cap_host = 1'b1;
                        load_d   = 1'b1;
                        state_d  = ST_TX_EMPTY;
                    end
                end
                ST_TX_EMPTY: begin
                    if (ev_nack) state_d = ST_IDLE;
                    else if (ev_ack) begin
                        if (no_stretch) begin
                            ovr_d  = 1'b1;
                            load_d = 1'b1;   // resend previous byte
                        end else begin
                            state_d = ST_TX_STALL;
                        end
                    end else if (host_wr) begin
                        cap_host = 1'b1;
                        state_d  = ST_TX_FULL;
                    end
                end
                ST_TX_FULL: begin
                    if (ev_nack) state_d = ST_IDLE;
                    else if (ev_ack) begin
                        load_d  = 1'b1;
                        state_d = ST_TX_EMPTY;
                    end else if (host_wr) begin
                        cap_host = 1'b1;     // no collision detection
                    end
                end
                ST_TX_STALL: begin
                    if (ev_nack) state_d = ST_IDLE;
                    else if (host_wr && armed) begin
                        cap_host = 1'b1;
                        load_d   = 1'b1;
                        state_d  = ST_TX_EMPTY;
                    end
                end
                ST_RX_EMPTY: begin
                    if (ev_ack) begin
                        cap_rx  = 1'b1;
                        state_d = ST_RX_FULL;
                    end
                end
                ST_RX_FULL: begin
                    if (ev_ack) begin
                        if (no_stretch) ovr_d = 1'b1;
                        else            state_d = ST_RX_STALL;
                    end else if (host_rd) begin
                        state_d = ST_RX_EMPTY;
                    end
                end
                ST_RX_STALL: begin
                    if (host_rd && armed) begin
                        cap_rx  = 1'b1;
                        state_d = ST_RX_FULL;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        txe     = (state_q == ST_TX_START) || (state_q == ST_TX_EMPTY) ||
                  (state_q == ST_TX_STALL);
        rxne    = (state_q == ST_RX_FULL) || (state_q == ST_RX_STALL);
        btf     = (state_q == ST_TX_STALL) || (state_q == ST_RX_STALL);
        stretch = btf;
        tx_load = load_q;
        ovr     = ovr_q;
    end
endmodule

// File: rtl/i2c_dbuf_ctrl.sv
module i2c_dbuf_ctrl #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          no_stretch,
    input  logic          addr_done,
    input  logic          dir_tx,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          ev_arlo,
    input  logic          ev_ack,
    input  logic          ev_nack,
    input  logic [DW-1:0] rx_byte,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    input  logic          sr1_rd,
    output logic [DW-1:0] buf_data,
    output logic          tx_load,
    output logic          txe,
    output logic          rxne,
    output logic          btf,
    output logic          stretch,
    output logic          ovr
);
    logic armed;
    logic cap_host;
    logic cap_rx;

    i2c_dbuf_arm u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .sr1_rd    (sr1_rd),
        .dr_access (host_wr | host_rd),
        .armed     (armed)
    );

    i2c_dbuf_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .no_stretch (no_stretch),
        .addr_done  (addr_done),
        .dir_tx     (dir_tx),
        .ev_start   (ev_start),
        .ev_stop    (ev_stop),
        .ev_arlo    (ev_arlo),
        .ev_ack     (ev_ack),
        .ev_nack    (ev_nack),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .armed      (armed),
        .cap_host   (cap_host),
        .cap_rx     (cap_rx),
        .tx_load    (tx_load),
        .txe        (txe),
        .rxne       (rxne),
        .btf        (btf),
        .stretch    (stretch),
        .ovr        (ovr)
    );

    i2c_dbuf_store #(.DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .cap_host (cap_host),
        .cap_rx   (cap_rx),
        .wdata    (host_wdata),
        .rx_byte  (rx_byte),
        .data_q   (buf_data)
    );
endmodule

// File: rtl/i2c_dbuf_chk.sv
module i2c_dbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic no_stretch,
    input logic addr_done,
    input logic ev_start,
    input logic ev_stop,
    input logic ev_arlo,
    input logic ev_nack,
    input logic tx_load,
    input logic txe,
    input logic rxne,
    input logic btf,
    input logic ovr
);
    a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!txe && !rxne && !btf && !ovr));

    a_r2_bus_event_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (ev_start || ev_stop)) |=> (!txe && !rxne && !btf));

    a_r10_nack_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ev_nack && !ev_start && !ev_stop && !ev_arlo && !addr_done)
        |=> (!tx_load && !txe));

    a_r11_no_btf_without_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && no_stretch && !btf) |=> !btf);

    a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ovr) |=> ovr);

    a_r13_arlo_no_rxne: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ev_arlo) |=> (!rxne && !btf));
endmodule

bind i2c_dbuf_ctrl i2c_dbuf_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .no_stretch (no_stretch),
    .addr_done  (addr_done),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .ev_arlo    (ev_arlo),
    .ev_nack    (ev_nack),
    .tx_load    (tx_load),
    .txe        (txe),
    .rxne       (rxne),
    .btf        (btf),
    .ovr        (ovr)
);

// File: tb/sim_i2c_dbuf_ctrl.sv
module sim_i2c_dbuf_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, no_stretch = 1'b0, addr_done = 1'b0, dir_tx = 1'b0;
    logic ev_start = 1'b0, ev_stop = 1'b0, ev_arlo = 1'b0, ev_ack = 1'b0, ev_nack = 1'b0;
    logic [DW-1:0] rx_byte = '0, host_wdata = '0;
    logic host_wr = 1'b0, host_rd = 1'b0, sr1_rd = 1'b0;
    logic [DW-1:0] buf_data;
    logic tx_load, txe, rxne, btf, stretch, ovr;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string cur_req = "R1";
    logic [DW-1:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_dbuf_ctrl #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .no_stretch(no_stretch),
        .addr_done(addr_done), .dir_tx(dir_tx), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_arlo(ev_arlo), .ev_ack(ev_ack), .ev_nack(ev_nack), .rx_byte(rx_byte),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata), .sr1_rd(sr1_rd),
        .buf_data(buf_data), .tx_load(tx_load), .txe(txe), .rxne(rxne), .btf(btf),
        .stretch(stretch), .ovr(ovr)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Advance one clock; the preceding posedge samples the driven inputs.
    task automatic tick();
        @(negedge clk);
        addr_done = 1'b0; ev_start = 1'b0; ev_stop = 1'b0; ev_arlo = 1'b0;
        ev_ack = 1'b0; ev_nack = 1'b0; host_wr = 1'b0; host_rd = 1'b0; sr1_rd = 1'b0;
    endtask

    task automatic push_load(input logic [DW-1:0] b);
        exp_q.push_back(b);
    endtask

    task automatic flags(input string req, input logic t, input logic r,
                         input logic b, input logic o);
        logic [4:0] act, exp;
        act = {txe, rxne, btf, stretch, ovr};
        exp = {t, r, b, b, o};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s flags txe/rxne/btf/stretch/ovr act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic data(input string req, input logic [DW-1:0] e);
        n_vec++;
        if (buf_data !== e) begin
            n_bad++;
            $display("FAIL %s buf_data act=%h exp=%h", req, buf_data, e);
        end
    endtask

    // Monitor: every load pulse pops one expected byte
    always @(posedge clk) begin
        #1;
        if (rst_n && tx_load === 1'b1) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL %s unexpected tx_load act=%h exp=none", cur_req, buf_data);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                if (buf_data !== e) begin
                    n_bad++;
                    $display("FAIL %s tx_load byte act=%h exp=%h", cur_req, buf_data, e);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        flags("R1", 0, 0, 0, 0);
        enable = 1'b1; tick();

        // R2: address phase keeps txe low
        cur_req = "R2"; ev_start = 1'b1; tick(); tick();
        flags("R2", 0, 0, 0, 0);
        addr_done = 1'b1; dir_tx = 1'b1; tick();
        flags("R2", 1, 0, 0, 0);

        // R3: first byte goes straight to the shifter
        cur_req = "R3"; push_load(8'hA5);
        host_wr = 1'b1; host_wdata = 8'hA5; tick();
        flags("R3", 1, 0, 0, 0);
        // R4
        cur_req = "R4"; host_wr = 1'b1; host_wdata = 8'h3C; tick();
        flags("R4", 0, 0, 0, 0);
        // R5
        cur_req = "R5"; push_load(8'h3C); ev_ack = 1'b1; tick();
        flags("R5", 1, 0, 0, 0);
        // R6: underrun while stretching
        cur_req = "R6"; ev_ack = 1'b1; tick();
        flags("R6", 1, 0, 1, 0);
        // R7: unarmed write ignored
        cur_req = "R7"; host_wr = 1'b1; host_wdata = 8'h77; tick();
        flags("R7", 1, 0, 1, 0);
        data("R7", 8'h3C);
        // R8: armed write resumes
        cur_req = "R8"; sr1_rd = 1'b1; tick();
        push_load(8'h77); host_wr = 1'b1; host_wdata = 8'h77; tick();
        flags("R8", 1, 0, 0, 0);
        // R9: overwrite while txe=0
        cur_req = "R9"; host_wr = 1'b1; host_wdata = 8'h11; tick();
        flags("R9", 0, 0, 0, 0);
        host_wr = 1'b1; host_wdata = 8'h22; tick();
        push_load(8'h22); ev_ack = 1'b1; tick();
        flags("R9", 1, 0, 0, 0);
        // R10: NACK
        cur_req = "R10"; ev_nack = 1'b1; tick(); tick();
        flags("R10", 0, 0, 0, 0);
        // R2: start clears txe
        cur_req = "R2"; addr_done = 1'b1; dir_tx = 1'b1; tick();
        flags("R2", 1, 0, 0, 0);
        ev_start = 1'b1; tick();
        flags("R2", 0, 0, 0, 0);

        // R11: no-stretch underrun resends
        cur_req = "R11"; no_stretch = 1'b1;
        addr_done = 1'b1; dir_tx = 1'b1; tick();
        push_load(8'h5A); host_wr = 1'b1; host_wdata = 8'h5A; tick();
        push_load(8'h5A); ev_ack = 1'b1; tick();
        flags("R11", 1, 0, 0, 1);
        push_load(8'h5A); ev_ack = 1'b1; tick();
        flags("R11", 1, 0, 0, 1);
        // R1: disable clears everything
        cur_req = "R1"; enable = 1'b0; tick();
        flags("R1", 0, 0, 0, 0);
        enable = 1'b1; tick();

        // R12: receive path with stretching
        cur_req = "R12"; no_stretch = 1'b0; ev_stop = 1'b1; tick();
        addr_done = 1'b1; dir_tx = 1'b0; tick();
        flags("R12", 0, 0, 0, 0);
        rx_byte = 8'hC3; ev_ack = 1'b1; tick();
        flags("R12", 0, 1, 0, 0);
        data("R12", 8'hC3);
        rx_byte = 8'hD4; ev_ack = 1'b1; tick();
        flags("R12", 0, 1, 1, 0);
        data("R12", 8'hC3);
        cur_req = "R7"; host_rd = 1'b1; tick();
        flags("R7", 0, 1, 1, 0);
        data("R7", 8'hC3);
        cur_req = "R12"; sr1_rd = 1'b1; tick();
        host_rd = 1'b1; tick();
        flags("R12", 0, 1, 0, 0);
        data("R12", 8'hD4);
        host_rd = 1'b1; tick();
        flags("R12", 0, 0, 0, 0);
        // R13: arbitration loss on ACK
        cur_req = "R13"; rx_byte = 8'h99; ev_ack = 1'b1; ev_arlo = 1'b1; tick();
        flags("R13", 0, 0, 0, 0);
        data("R13", 8'hD4);
        ev_ack = 1'b1; tick();
        flags("R13", 0, 0, 0, 0);

        // R14: no-stretch overrun drops the new byte
        cur_req = "R14"; no_stretch = 1'b1;
        addr_done = 1'b1; dir_tx = 1'b0; tick();
        rx_byte = 8'hE1; ev_ack = 1'b1; tick();
        flags("R14", 0, 1, 0, 0);
        rx_byte = 8'hF2; ev_ack = 1'b1; tick();
        flags("R14", 0, 1, 0, 1);
        data("R14", 8'hE1);

        tick();
        n_vec++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R5 pending loads act=%0d exp=0", exp_q.size());
        end
        done = 1'b1;
        report();
        $finish;
    end
endmodule